// File: doc/BRIEF.md
# Static-Memory Bus Master with Line Transfers

This block is the controller side of an asynchronous static-memory bus. An internal requester hands it one read or write at a time over a valid/ready handshake. The block turns each request into strobe-driven bus cycles on a 26-bit address bus. The data bus is fixed at build time to either 16 or 32 bits. A zero-wait beat takes exactly two clocks: a first phase that opens the cycle and a second phase that closes it. Read data is returned over an acknowledge pulse that follows every beat.

The block supports single accesses of one, two or four bytes, and 32-byte line transfers. A line transfer starts with the word that was asked for. It then steps by the bus width and wraps inside the aligned 32-byte block until the whole block has moved. Write data for each beat is pulled from the requester one beat at a time through a take strobe.

The bus stays owned for the whole transfer. When the requester has the next request waiting, a new access can follow the last beat with no idle cycle. In that case chip select stays low across the join.

Top module: `sbus_master`

## Requirements
- R1: After reset, with no request pending, bus_cs_n, bus_bs_n and bus_rd_n are high, all bus_we_n lines are high, bus_doe is low, rsp_ack is low and req_ready is high.
- R2: Each beat lasts two cycles. bus_bs_n is low in the first cycle (T1) and high in the second (T2). bus_din is captured at the end of T2. rsp_ack is high for one cycle, two cycles after the T1 cycle, with the captured word on rsp_rdata.
- R3: bus_bs_n is low for exactly one cycle per beat, so the number of bus_bs_n low cycles equals the number of beats.
- R4: bus_cs_n is low through T1 and T2 of every beat. For consecutive beats, and for a request accepted in the last T2 of the previous access, the next T1 follows that T2 at once and bus_cs_n stays low with no gap.
- R5: bus_addr is 26 bits and holds steady across T1 and T2. For a single access that fits the bus, it equals the requested address unchanged.
- R6: A read drives bus_rd_n low and keeps every bus_we_n line high, whatever the requested size. rsp_rdata is always the full bus word.
- R7: A single write drives bus_we_n low only for the byte lanes being written. The lanes run from a = addr mod (bus bytes) up to a + 2^size - 1. Lane i is data bits [8i+7:8i]. The size codes are 0 = byte, 1 = halfword and 2 = word. The request is aligned to its size.
- R8: On a 16-bit bus, a single word (size 2) access runs as two beats, at addresses A and A+2, where A is the address with bits [1:0] cleared. Both beats use all lanes.
- R9: A line transfer (req_line = 1) runs 32/(bus bytes) beats: 8 beats on a 32-bit bus and 16 beats on a 16-bit bus. The first beat uses the requested address with its lane bits cleared. Each later beat adds the bus width to bits [4:0] modulo 32. Bits [25:5] do not change.
- R10: Line writes enable all lanes on every beat. The data for each write beat is the value on req_wdata at the clock edge that closes a cycle in which wd_take is high. Write beats consume that data in order.
- R11: req_ready stays low from acceptance until the T2 of the final beat. rsp_last is high only with the acknowledge of the final beat of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 32-byte line transfer |
| req_size | input | 2 | Single access size: 0 byte, 1 half, 2 word |
| req_addr | input | 26 | Byte address |
| req_wdata | input | BUS_W | Lane-aligned write data for the beat being launched |
| wd_take | output | 1 | req_wdata is consumed at the closing edge of this cycle |
| rsp_ack | output | 1 | One pulse per completed beat |
| rsp_last | output | 1 | Marks the acknowledge of the final beat |
| rsp_rdata | output | BUS_W | Read word captured at the end of T2 |
| bus_bs_n | output | 1 | Bus-start strobe, low in T1 |
| bus_cs_n | output | 1 | Chip select, low over T1 and T2 |
| bus_rd_n | output | 1 | Read strobe |
| bus_we_n | output | BUS_W/8 | Per-lane write enables, active low |
| bus_addr | output | 26 | External address |
| bus_dout | output | BUS_W | Write data to the bus |
| bus_doe | output | 1 | Data drive enable for writes |
| bus_din | input | BUS_W | Read data from the bus |

## Verification
Two things can land in the same cycle. One is the acceptance of a new request. The other is the T2 phase that closes the final beat of the access already on the bus. When they coincide, the next T1 must follow at once, with chip select unbroken. The stimulus provokes this by issuing every request in a group while the previous one is still running, so that each acceptance happens in a final T2. Such joins include a line transfer followed by a single write, and a split word followed by a line. The result is judged from the bus record: each bus-start must sit exactly two cycles after the one before it, and the count of chip-select low cycles for the group must equal twice its beat count.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   // bus phase of the controller
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_T1   = 2'd1,
      PH_T2   = 2'd2
   } phase_e;

   // size codes carried on req_size
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   // line geometry
   localparam int LINE_BYTES = 32;
   localparam int LINE_LG    = 5;
   localparam int WORD_LG    = 2;

endpackage

// File: rtl/sbus_addr_gen.sv
module sbus_addr_gen
   import sbus_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int BUS_BYTES = 4,
   parameter int CNT_W     = 3
) (
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_line,
   input  logic               req_split,
   input  logic [ADDR_W-1:0]  cur_addr,
   input  logic [LINE_LG-1:0] cur_mask,
   output logic [ADDR_W-1:0]  start_addr,
   output logic [CNT_W-1:0]   start_cnt,
   output logic [LINE_LG-1:0] start_mask,
   output logic [ADDR_W-1:0]  next_addr
);
   localparam int LANE_W     = $clog2(BUS_BYTES);
   localparam int LINE_BEATS = LINE_BYTES / BUS_BYTES;

   if (LINE_BEATS > (1 << CNT_W)) begin : g_bad_cnt
      $error("sbus_addr_gen: CNT_W too small for a line");
   end

   logic [ADDR_W-1:0] wide_mask;
   logic [ADDR_W-1:0] bumped;

   // first beat: lane-aligned for lines, word-aligned for split words
   always_comb begin
      if (req_line) begin
         start_addr = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
         start_cnt  = CNT_W'(LINE_BEATS - 1);
         start_mask = LINE_LG'(LINE_BYTES - 1);
      end else if (req_split) begin
         start_addr = {req_addr[ADDR_W-1:WORD_LG], {WORD_LG{1'b0}}};
         start_cnt  = CNT_W'(1);
         start_mask = LINE_LG'(3);
      end else begin
         start_addr = req_addr;
         start_cnt  = '0;
         start_mask = LINE_LG'(3);
      end
   end

   // later beats: step by the bus width, wrap inside the block mask
   assign wide_mask = {{(ADDR_W-LINE_LG){1'b0}}, cur_mask};
   assign bumped    = cur_addr + ADDR_W'(BUS_BYTES);
   assign next_addr = (cur_addr & ~wide_mask) | (bumped & wide_mask);

endmodule

// File: rtl/sbus_lane_dec.sv
module sbus_lane_dec #(
   parameter int BUS_BYTES = 4,
   parameter int LANE_W    = 2
) (
   input  logic [LANE_W-1:0]    lane,
   input  logic [1:0]           size,
   input  logic                 multi,
   output logic [BUS_BYTES-1:0] be
);
   if (BUS_BYTES != (1 << LANE_W)) begin : g_bad_lane
      $error("sbus_lane_dec: LANE_W does not match BUS_BYTES");
   end

   logic [2:0] span;
   assign span = 3'd1 << size;

   for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
      assign be[i] = multi ||
                     ((i >= int'(lane)) && (i < int'(lane) + int'(span)));
   end

endmodule

// File: rtl/sbus_master.sv
module sbus_master
   import sbus_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int BUS_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic               req_line,
   input  logic [1:0]         req_size,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [BUS_W-1:0]   req_wdata,
   output logic               wd_take,
   output logic               rsp_ack,
   output logic               rsp_last,
   output logic [BUS_W-1:0]   rsp_rdata,
   output logic               bus_bs_n,
   output logic               bus_cs_n,
   output logic               bus_rd_n,
   output logic [BUS_W/8-1:0] bus_we_n,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [BUS_W-1:0]   bus_dout,
   output logic               bus_doe,
   input  logic [BUS_W-1:0]   bus_din
);
   localparam int BUS_BYTES  = BUS_W / 8;
   localparam int LANE_W     = $clog2(BUS_BYTES);
   localparam int LINE_BEATS = LINE_BYTES / BUS_BYTES;
   localparam int CNT_W      = $clog2(LINE_BEATS);

   if (BUS_W != 16 && BUS_W != 32) begin : g_bad_bus
      $error("sbus_master: BUS_W must be 16 or 32");
   end
   if (ADDR_W < LINE_LG + 1) begin : g_bad_addr
      $error("sbus_master: ADDR_W too narrow for line wrapping");
   end

   phase_e             ph;
   logic [CNT_W-1:0]   left;
   logic [LINE_LG-1:0] mask_q;
   logic               wr_q;

   logic               req_split;
   logic               start_multi;
   logic [ADDR_W-1:0]  start_addr;
   logic [CNT_W-1:0]   start_cnt;
   logic [LINE_LG-1:0] start_mask;
   logic [ADDR_W-1:0]  next_addr;
   logic [BUS_BYTES-1:0] be_new;

   logic last_beat, closing, launch, cont;

   // a word wider than the bus is split into two beats
   assign req_split   = (BUS_BYTES == 2) && !req_line && (req_size == SZ_WORD);
   assign start_multi = req_line | req_split;

   sbus_addr_gen #(
      .ADDR_W    (ADDR_W),
      .BUS_BYTES (BUS_BYTES),
      .CNT_W     (CNT_W)
   ) u_addr (
      .req_addr   (req_addr),
      .req_line   (req_line),
      .req_split  (req_split),
      .cur_addr   (bus_addr),
      .cur_mask   (mask_q),
      .start_addr (start_addr),
      .start_cnt  (start_cnt),
      .start_mask (start_mask),
      .next_addr  (next_addr)
   );

   sbus_lane_dec #(
      .BUS_BYTES (BUS_BYTES),
      .LANE_W    (LANE_W)
   ) u_lane (
      .lane  (req_addr[LANE_W-1:0]),
      .size  (req_size),
      .multi (start_multi),
      .be    (be_new)
   );

   assign last_beat = (left == '0);
   assign closing   = (ph == PH_T2);
   assign req_ready = (ph == PH_IDLE) || (closing && last_beat);
   assign launch    = req_valid && req_ready;
   assign cont      = closing && !last_beat;
   assign wd_take   = (launch && req_write) || (cont && wr_q);

   // response path: one acknowledge per closed beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ack   <= 1'b0;
         rsp_last  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_ack  <= closing;
         rsp_last <= closing && last_beat;
         if (closing && !wr_q) rsp_rdata <= bus_din;
      end
   end

   // bus sequencer with registered strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         left     <= '0;
         mask_q   <= '0;
         wr_q     <= 1'b0;
         bus_bs_n <= 1'b1;
         bus_cs_n <= 1'b1;
         bus_rd_n <= 1'b1;
         bus_we_n <= '1;
         bus_addr <= '0;
         bus_dout <= '0;
         bus_doe  <= 1'b0;
      end else if (launch) begin
         ph       <= PH_T1;
         left     <= start_cnt;
         mask_q   <= start_mask;
         wr_q     <= req_write;
         bus_bs_n <= 1'b0;
         bus_cs_n <= 1'b0;
         bus_rd_n <= req_write;
         bus_we_n <= req_write ? ~be_new : '1;
         bus_addr <= start_addr;
         bus_dout <= req_wdata;
         bus_doe  <= req_write;
      end else if (cont) begin
         ph       <= PH_T1;
         left     <= left - 1'b1;
         bus_bs_n <= 1'b0;
         bus_addr <= next_addr;
         if (wr_q) bus_dout <= req_wdata;
      end else if (ph == PH_T1) begin
         ph       <= PH_T2;
         bus_bs_n <= 1'b1;
      end else if (closing) begin
         ph       <= PH_IDLE;
         bus_cs_n <= 1'b1;
         bus_rd_n <= 1'b1;
         bus_we_n <= '1;
         bus_doe  <= 1'b0;
      end
   end

endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
   parameter int ADDR_W = 26,
   parameter int BUS_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_ack,
   input logic               rsp_last,
   input logic               bus_bs_n,
   input logic               bus_cs_n,
   input logic               bus_rd_n,
   input logic [BUS_W/8-1:0] bus_we_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_doe
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> (bus_bs_n && bus_rd_n && (&bus_we_n)));

   p_ack_after_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> $past(!bus_cs_n && bus_bs_n));

   p_bs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |=> bus_bs_n);

   p_cs_in_t1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |-> !bus_cs_n);

   p_cs_in_t2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |=> !bus_cs_n);

   p_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> $past(bus_bs_n));

   p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |=> $stable(bus_addr));

   p_read_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> ((&bus_we_n) && !bus_doe));

   p_hold_in_t1_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |-> !req_ready);

   p_last_with_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> rsp_ack);

endmodule

bind sbus_master sbus_master_chk #(
   .ADDR_W (ADDR_W),
   .BUS_W  (BUS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_ack   (rsp_ack),
   .rsp_last  (rsp_last),
   .bus_bs_n  (bus_bs_n),
   .bus_cs_n  (bus_cs_n),
   .bus_rd_n  (bus_rd_n),
   .bus_we_n  (bus_we_n),
   .bus_addr  (bus_addr),
   .bus_doe   (bus_doe)
);

// File: tb/sbus_env.sv
module sbus_env #(
   parameter int BW = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_chk,
   output int   n_fail
);
   localparam int BB = BW / 8;
   localparam int AW = 26;
   localparam int LG = 4096;

   logic          req_valid;
   logic          req_ready;
   logic          req_write;
   logic          req_line;
   logic [1:0]    req_size;
   logic [AW-1:0] req_addr;
   logic [BW-1:0] req_wdata;
   logic          wd_take;
   logic          rsp_ack, rsp_last;
   logic [BW-1:0] rsp_rdata;
   logic          bus_bs_n, bus_cs_n, bus_rd_n, bus_doe;
   logic [BB-1:0] bus_we_n;
   logic [AW-1:0] bus_addr;
   logic [BW-1:0] bus_dout, bus_din;

   function automatic logic [BW-1:0] wpat(int i);
      logic [31:0] v;
      v = 32'hA5C3_0000 ^ (i * 32'h9E37_79B1);
      return v[BW-1:0];
   endfunction

   function automatic logic [BW-1:0] rpat(logic [AW-1:0] a);
      logic [31:0] v;
      v = {a[15:0], ~a[15:0]} ^ {6'h2B, a};
      return v[BW-1:0];
   endfunction

   int widx;
   always @(posedge clk or negedge rst_n)
      if (!rst_n) widx <= 0;
      else if (wd_take) widx <= widx + 1;

   assign req_wdata = wpat(widx);
   assign bus_din   = rpat(bus_addr);

   sbus_master #(.ADDR_W(AW), .BUS_W(BW)) i_sbus_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_line(req_line), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .wd_take(wd_take),
      .rsp_ack(rsp_ack), .rsp_last(rsp_last), .rsp_rdata(rsp_rdata),
      .bus_bs_n(bus_bs_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
      .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .bus_din(bus_din)
   );

   // bus and response record, sampled at the falling edge
   logic [AW-1:0] m_addr [LG];
   logic [BB-1:0] m_wen  [LG];
   logic          m_rd   [LG];
   logic [BW-1:0] m_dout [LG];
   int            m_cyc  [LG];
   logic [BW-1:0] a_data [LG];
   logic          a_last [LG];
   int            a_cyc  [LG];
   int mb = 0, ma = 0, cyc = 0, cs_lo = 0;

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (!bus_cs_n) cs_lo++;
      if (!bus_bs_n && mb < LG) begin
         m_addr[mb] = bus_addr; m_wen[mb] = bus_we_n; m_rd[mb] = bus_rd_n;
         m_dout[mb] = bus_dout; m_cyc[mb] = cyc; mb++;
      end
      if (rsp_ack && ma < LG) begin
         a_data[ma] = rsp_rdata; a_last[ma] = rsp_last; a_cyc[ma] = cyc; ma++;
      end
   end

   // expected beats
   logic [AW-1:0] e_addr  [LG];
   logic [BB-1:0] e_wen   [LG];
   logic          e_wr    [LG];
   logic          e_line  [LG];
   logic          e_split [LG];
   logic [BW-1:0] e_dout  [LG];
   logic [BW-1:0] e_rdata [LG];
   logic          e_last  [LG];
   int ne = 0, exp_w = 0, cb = 0, cs0 = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s (bus %0d) got %h exp %h", tag, what, BW, got, exp);
      end
   endtask

   task automatic push_txn(bit we, bit ln, logic [1:0] sz, logic [AW-1:0] ad);
      int nb;
      logic [AW-1:0] a0, m26, a;
      int lane;
      nb  = ln ? 32 / BB : ((BB == 2 && sz == 2'd2) ? 2 : 1);
      m26 = ln ? AW'(31) : AW'(3);
      if (ln) a0 = ad & ~AW'(BB - 1);
      else if (nb == 2) a0 = ad & ~AW'(3);
      else a0 = ad;
      lane = int'(ad) % BB;
      for (int i = 0; i < nb; i++) begin
         a = (a0 & ~m26) | ((a0 + AW'(i * BB)) & m26);
         e_addr[ne] = a; e_wr[ne] = we; e_line[ne] = ln; e_split[ne] = (nb == 2) && !ln;
         e_rdata[ne] = rpat(a); e_last[ne] = (i == nb - 1);
         e_wen[ne] = '1;
         if (we) begin
            for (int l = 0; l < BB; l++)
               if (nb > 1 || (l >= lane && l < lane + (1 << sz))) e_wen[ne][l] = 1'b0;
            e_dout[ne] = wpat(exp_w); exp_w++;
         end else e_dout[ne] = '0;
         ne++;
      end
   endtask

   task automatic issue(bit we, bit ln, logic [1:0] sz, logic [AW-1:0] ad);
      push_txn(we, ln, sz, ad);
      req_write = we; req_line = ln; req_size = sz; req_addr = ad; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic begin_batch();
      cs0 = cs_lo;
   endtask

   task automatic settle();
      string tg;
      while (ma < ne) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(mb == ne, "R3", "bus-start count", mb, ne);
      chk(cs_lo - cs0 == 2 * (ne - cb), "R4", "chip-select low cycles", cs_lo - cs0, 2 * (ne - cb));
      chk(req_ready === 1'b1, "R11", "ready after access", req_ready, 1);
      for (int i = cb; i < ne; i++) begin
         tg = e_line[i] ? "R9" : (e_split[i] ? "R8" : "R5");
         chk(m_addr[i] == e_addr[i], tg, "address", m_addr[i], e_addr[i]);
         tg = !e_wr[i] ? "R6" : (e_line[i] ? "R10" : "R7");
         chk(m_wen[i] == e_wen[i], tg, "write enables", m_wen[i], e_wen[i]);
         chk(m_rd[i] == e_wr[i], "R6", "read strobe", m_rd[i], e_wr[i]);
         if (e_wr[i]) chk(m_dout[i] == e_dout[i], "R10", "write data", m_dout[i], e_dout[i]);
         else chk(a_data[i] == e_rdata[i], "R6", "read data", a_data[i], e_rdata[i]);
         chk(a_cyc[i] == m_cyc[i] + 2, "R2", "ack cycle", a_cyc[i], m_cyc[i] + 2);
         chk(a_last[i] == e_last[i], "R11", "last flag", a_last[i], e_last[i]);
         if (i > cb) chk(m_cyc[i] == m_cyc[i-1] + 2, "R4", "beat pitch", m_cyc[i], m_cyc[i-1] + 2);
      end
      cb = ne;
   endtask

   initial begin
      logic [AW-1:0] ad;
      logic [1:0] sz;
      bit we, ln;
      int k;
      done = 1'b0; n_chk = 0; n_fail = 0;
      req_valid = 1'b0; req_write = 1'b0; req_line = 1'b0; req_size = '0; req_addr = '0;
      void'($urandom(32'd5150 + BW));
      wait (rst_n === 1'b1);
      @(negedge clk);
      // R1 reset state
      chk(bus_cs_n && bus_bs_n && bus_rd_n, "R1", "strobes idle", {bus_cs_n, bus_bs_n, bus_rd_n}, 3'b111);
      chk(&bus_we_n, "R1", "write enables idle", bus_we_n, '1);
      chk(!bus_doe && !rsp_ack && req_ready, "R1", "doe/ack/ready", {bus_doe, rsp_ack, req_ready}, 3'b001);

      // R6 byte read at the top lane still returns the full bus
      begin_batch(); issue(0, 0, 2'd0, 26'h012_3403 & ~AW'(BB == 2 ? 0 : 0)); settle();
      // R7 partial writes
      begin_batch(); issue(1, 0, 2'd1, 26'h000_0102); settle();
      begin_batch(); issue(1, 0, 2'd0, 26'h000_0101); settle();
      // R9 line read that wraps from offset 0x1C
      begin_batch(); issue(0, 1, 2'd2, 26'h2AB_CD5C); settle();
      // R10 line write from offset 0x08
      begin_batch(); issue(1, 1, 2'd2, 26'h001_0008); settle();
      // R8 / R5 word access
      begin_batch(); issue(0, 0, 2'd2, 26'h3FF_FFFC); issue(1, 0, 2'd2, 26'h000_0444); settle();
      // R4 R11 back-to-back joins: line then single, single then line
      begin_batch();
      issue(0, 1, 2'd0, 26'h100_0014);
      issue(1, 0, 2'd0, 26'h100_0003);
      issue(0, 0, 2'd1, 26'h100_0006);
      issue(1, 1, 2'd0, 26'h100_003E);
      settle();

      // constrained random groups, each request queued behind the previous
      for (int g = 0; g < 40; g++) begin
         begin_batch();
         k = 1 + int'($urandom % 3);
         for (int j = 0; j < k; j++) begin
            we = 1'($urandom);
            ln = ($urandom % 4) == 0;
            sz = 2'($urandom % 3);
            ad = AW'($urandom);
            if (!ln) ad = ad & ~AW'((1 << sz) - 1);
            issue(we, ln, sz, ad);
         end
         settle();
      end
      done = 1'b1;
   end

endmodule

// File: tb/test_sbus_master.sv
module test_sbus_master;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic d32, d16;
   int   c32, f32, c16, f16;

   sbus_env #(.BW(32)) u_env32 (.clk(clk), .rst_n(rst_n), .done(d32), .n_chk(c32), .n_fail(f32));
   sbus_env #(.BW(16)) u_env16 (.clk(clk), .rst_n(rst_n), .done(d16), .n_chk(c16), .n_fail(f16));

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
   end

   initial begin
      int cycles;
      int total, failed;
      bit hung;
      cycles = 0;
      hung = 1'b0;
      #1;
      while (!(d32 === 1'b1 && d16 === 1'b1)) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            hung = 1'b1;
            break;
         end
      end
      total  = c32 + c16;
      failed = f32 + f16;
      if (hung) begin
         total++;
         failed++;
         $display("FAIL watchdog: run did not complete, got %0d cycles exp under 150000", cycles);
      end
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule